// File: doc/BRIEF.md
# Multi-Channel Common Sampling Phase Calibrator

The calibrator finds one sampling delay that suits every input lane of a wide parallel receiver and applies it to all lanes together. On a start pulse it steps a shared delay-select code through every candidate tap while the far end sends a fixed training word on every lane. Each tap stays selected for a fixed number of dwell cycles. A tap counts as good only if every lane returns the training word on every dwell cycle of that tap. The good taps form a common window. The calibrator picks the centre of the longest contiguous run of good taps and drives that tap onto the shared delay select.

After the choice is applied, the calibrator checks a fixed-length run of verify vectors with the new tap in place and counts the vectors in which any lane differs from the training word. A clean run ends in the DONE state. A run with any error, or a scan that found no usable tap at all, ends in the FAIL state. A failed scan leaves the previous tap in force.

The states, with their codes on `cal_state`, are IDLE (0), SCAN (1), SELECT (2), VERIFY (3), DONE (4) and FAIL (5). The transitions are these:
- IDLE, DONE or FAIL go to SCAN on `start`.
- SCAN goes to SELECT after the dwell period of the last tap.
- SELECT goes to FAIL when the window is empty, and to VERIFY otherwise.
- VERIFY goes to DONE or to FAIL after its last vector.

Top module: `lane_phase_calibrator`

## Requirements
- R1: After reset, `cal_state` is 0 (IDLE), `busy`, `done`, `fail` and `no_window` are low, and `delay_sel`, `chosen_tap`, `win_width` and `verr_cnt` are 0.
- R2: A `start` pulse in IDLE, DONE or FAIL begins a new scan with the window, width, error count and no-window flag cleared. A `start` pulse while `busy` is high is ignored, and the scan in progress continues unchanged.
- R3: In SCAN, `delay_sel` starts at 0 and rises by one after every DWELL cycles, up to NUM_TAPS-1. SELECT follows the last dwell cycle of the last tap.
- R4: A tap belongs to the common window only if, on every one of its dwell cycles, every lane's word in `rx_words` equals TRAIN_WORD. Lane c occupies bits [c*WORD_W +: WORD_W]. A single mismatching cycle on a single lane removes the tap.
- R5: The chosen tap is s + (L-1)/2 (integer division), where s is the first tap and L the length of the longest contiguous run in the window. When runs tie, the lowest-numbered run wins. L is reported on `win_width`.
- R6: Outside SCAN, `delay_sel` equals `chosen_tap`. One code serves all lanes. It stays constant through VERIFY.
- R7: If the window is empty, the block goes to FAIL with `no_window` high and `win_width` 0. `delay_sel` and `chosen_tap` keep their value from before the scan.
- R8: VERIFY lasts VERIFY_LEN cycles. `verr_cnt` ends equal to the number of those cycles in which at least one lane mismatches. A count of zero leads to DONE, and any other count leads to FAIL with `no_window` low.
- R9: `busy` is high exactly in SCAN, SELECT and VERIFY. `done` is high only in DONE and `fail` only in FAIL. Both hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run |
| rx_words | input | NUM_CH*WORD_W | Received word of every lane, lane 0 in the low bits |
| delay_sel | output | TAP_W | Shared delay tap applied to all lanes |
| chosen_tap | output | TAP_W | Tap kept as the result of the last successful selection |
| win_width | output | LEN_W | Length of the longest common passing run |
| verr_cnt | output | VERR_W | Vectors with a mismatch during VERIFY |
| no_window | output | 1 | No tap passed on every lane |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration verified clean |
| fail | output | 1 | Calibration failed |
| cal_state | output | 3 | Current state code |

## Verification
On every cycle, the assertions check the following:
- the single-step climb of `delay_sel` through SCAN, starting at zero;
- the frozen delay through VERIFY;
- the held delay and cleared width when the window is empty;
- the mutual exclusion of the three status flags;
- that DONE never coexists with an error count or a missing window.

Only the bench scenarios can show that the right tap is chosen. The bench sweeps every possible common window of a small configuration and computes the centre of the longest run by its own search. Its scenarios also cover a single-cycle lane glitch inside one dwell period, errors on the first and last verify vectors, and a `start` pulse issued mid-scan.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SCAN   = 3'd1,
        ST_SELECT = 3'd2,
        ST_VERIFY = 3'd3,
        ST_DONE   = 3'd4,
        ST_FAIL   = 3'd5
    } cal_state_t;
endpackage

// File: rtl/lane_match.sv
// Compares every lane against the training word; reports whether all agree.
module lane_match #(
    parameter int               NUM_CH     = 108,
    parameter int               WORD_W     = 8,
    parameter logic [WORD_W-1:0] TRAIN_WORD = '0
) (
    input  logic [NUM_CH*WORD_W-1:0] rx_words,
    output logic                     all_ok
);
    logic [NUM_CH-1:0] hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        assign hit[c] = (rx_words[c*WORD_W +: WORD_W] == TRAIN_WORD);
    end

    assign all_ok = &hit;
endmodule

// File: rtl/window_pick.sv
// Finds the longest contiguous run of passing taps and its centre.
module window_pick #(
    parameter int NUM_TAPS = 16,
    parameter int TAP_W    = 4,
    parameter int LEN_W    = 5
) (
    input  logic [NUM_TAPS-1:0] win,
    output logic [LEN_W-1:0]    best_len,
    output logic [TAP_W-1:0]    centre
);
    logic [LEN_W-1:0] run_len;
    logic [TAP_W-1:0] run_st;
    logic [TAP_W-1:0] best_st;

    always_comb begin
        run_len  = '0;
        run_st   = '0;
        best_len = '0;
        best_st  = '0;
        for (int t = 0; t < NUM_TAPS; t++) begin
            if (win[t]) begin
                if (run_len == '0) begin
                    run_st = TAP_W'(t);
                end
                run_len = run_len + LEN_W'(1);
                if (run_len > best_len) begin
                    best_len = run_len;
                    best_st  = run_st;
                end
            end else begin
                run_len = '0;
            end
        end
        centre = best_st + TAP_W'((best_len - LEN_W'(1)) >> 1);
    end
endmodule

// File: rtl/lane_phase_calibrator.sv
module lane_phase_calibrator
    import lpc_pkg::*;
#(
    parameter int                NUM_CH     = 108,
    parameter int                WORD_W     = 8,
    parameter logic [WORD_W-1:0] TRAIN_WORD = 8'hA5,
    parameter int                NUM_TAPS   = 16,
    parameter int                DWELL      = 8,
    parameter int                VERIFY_LEN = 256,
    localparam int               TAP_W      = $clog2(NUM_TAPS),
    localparam int               LEN_W      = $clog2(NUM_TAPS + 1),
    localparam int               VERR_W     = $clog2(VERIFY_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NUM_CH*WORD_W-1:0] rx_words,
    output logic [TAP_W-1:0]         delay_sel,
    output logic [TAP_W-1:0]         chosen_tap,
    output logic [LEN_W-1:0]         win_width,
    output logic [VERR_W-1:0]        verr_cnt,
    output logic                     no_window,
    output logic                     busy,
    output logic                     done,
    output logic                     fail,
    output logic [2:0]               cal_state
);
    localparam int DW_W   = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam int VCNT_W = (VERIFY_LEN > 1) ? $clog2(VERIFY_LEN) : 1;

    cal_state_t          state_q, state_d;
    logic [TAP_W-1:0]    scan_tap_q;
    logic [DW_W-1:0]     dwell_q;
    logic [VCNT_W-1:0]   vcnt_q;
    logic [NUM_TAPS-1:0] win_q;
    logic [TAP_W-1:0]    applied_q;
    logic [LEN_W-1:0]    width_q;
    logic [VERR_W-1:0]   verr_q;
    logic                nowin_q;

    logic                all_ok;
    logic [LEN_W-1:0]    best_len;
    logic [TAP_W-1:0]    centre;
    logic                tap_last, dwell_last, vec_last, idle_like;
    logic [VERR_W-1:0]   verr_next;

    lane_match #(
        .NUM_CH     (NUM_CH),
        .WORD_W     (WORD_W),
        .TRAIN_WORD (TRAIN_WORD)
    ) u_match (
        .rx_words (rx_words),
        .all_ok   (all_ok)
    );

    window_pick #(
        .NUM_TAPS (NUM_TAPS),
        .TAP_W    (TAP_W),
        .LEN_W    (LEN_W)
    ) u_pick (
        .win      (win_q),
        .best_len (best_len),
        .centre   (centre)
    );

    assign tap_last   = (scan_tap_q == TAP_W'(NUM_TAPS - 1));
    assign dwell_last = (dwell_q == DW_W'(DWELL - 1));
    assign vec_last   = (vcnt_q == VCNT_W'(VERIFY_LEN - 1));
    assign idle_like  = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
    assign verr_next  = verr_q + VERR_W'(!all_ok);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (dwell_last && tap_last) state_d = ST_SELECT;
            end
            ST_SELECT: begin
                state_d = (best_len == '0) ? ST_FAIL : ST_VERIFY;
            end
            ST_VERIFY: begin
                if (vec_last) state_d = (verr_next == '0) ? ST_DONE : ST_FAIL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Scan, selection and verify datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_tap_q <= '0;
            dwell_q    <= '0;
            vcnt_q     <= '0;
            win_q      <= '0;
            applied_q  <= '0;
            width_q    <= '0;
            verr_q     <= '0;
            nowin_q    <= 1'b0;
        end else begin
            if (idle_like) begin
                if (start) begin
                    scan_tap_q <= '0;
                    dwell_q    <= '0;
                    win_q      <= '1;
                    width_q    <= '0;
                    verr_q     <= '0;
                    nowin_q    <= 1'b0;
                end
            end else if (state_q == ST_SCAN) begin
                if (!all_ok) win_q[scan_tap_q] <= 1'b0;
                if (dwell_last) begin
                    dwell_q <= '0;
                    if (!tap_last) scan_tap_q <= scan_tap_q + TAP_W'(1);
                end else begin
                    dwell_q <= dwell_q + DW_W'(1);
                end
            end else if (state_q == ST_SELECT) begin
                vcnt_q <= '0;
                if (best_len == '0) begin
                    nowin_q <= 1'b1;
                end else begin
                    applied_q <= centre;
                    width_q   <= best_len;
                end
            end else if (state_q == ST_VERIFY) begin
                verr_q <= verr_next;
                vcnt_q <= vcnt_q + VCNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        delay_sel  = (state_q == ST_SCAN) ? scan_tap_q : applied_q;
        chosen_tap = applied_q;
        win_width  = width_q;
        verr_cnt   = verr_q;
        no_window  = nowin_q;
        busy       = (state_q == ST_SCAN) || (state_q == ST_SELECT) || (state_q == ST_VERIFY);
        done       = (state_q == ST_DONE);
        fail       = (state_q == ST_FAIL);
        cal_state  = state_q;
    end
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
    parameter int NUM_TAPS = 16,
    parameter int TAP_W    = 4,
    parameter int LEN_W    = 5,
    parameter int VERR_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TAP_W-1:0]  delay_sel,
    input logic [TAP_W-1:0]  chosen_tap,
    input logic [LEN_W-1:0]  win_width,
    input logic [VERR_W-1:0] verr_cnt,
    input logic              no_window,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [2:0]        cal_state
);
    AST_SCAN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_state == 3'd1 && $past(cal_state) != 3'd1) |-> (delay_sel == '0)); // R3

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_state == 3'd1 && $past(cal_state) == 3'd1) |->
        (delay_sel == $past(delay_sel) || delay_sel == TAP_W'($past(delay_sel) + 1'b1))); // R3

    AST_VERIFY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_state == 3'd3 && $past(cal_state) == 3'd3) |->
        ($stable(delay_sel) && delay_sel == chosen_tap)); // R6

    AST_WIDTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (win_width != '0 && win_width <= LEN_W'(NUM_TAPS))); // R5

    AST_NOWIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_window) |-> ($stable(delay_sel) && fail && win_width == '0)); // R7

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (verr_cnt == '0 && !no_window)); // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, fail})); // R9
endmodule

bind lane_phase_calibrator lpc_checker #(
    .NUM_TAPS (NUM_TAPS),
    .TAP_W    (TAP_W),
    .LEN_W    (LEN_W),
    .VERR_W   (VERR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .delay_sel  (delay_sel),
    .chosen_tap (chosen_tap),
    .win_width  (win_width),
    .verr_cnt   (verr_cnt),
    .no_window  (no_window),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .cal_state  (cal_state)
);

// File: tb/sim_lane_phase_calibrator.sv
module sim_lane_phase_calibrator;
    localparam int          NC    = 4;
    localparam int          W     = 8;
    localparam logic [7:0]  TRAIN = 8'h3C;
    localparam int          NT    = 8;
    localparam int          DW    = 4;
    localparam int          VL    = 256;
    localparam int          TAP_W = 3;
    localparam int          LEN_W = 4;
    localparam int          VERR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NC*W-1:0]   rx_words;
    logic [TAP_W-1:0]  delay_sel, chosen_tap;
    logic [LEN_W-1:0]  win_width;
    logic [VERR_W-1:0] verr_cnt;
    logic              no_window, busy, done, fail;
    logic [2:0]        cal_state;

    logic [NT-1:0]     good [NC];
    logic [NC-1:0]     inj = '0;

    int tests = 0;
    int fails = 0;
    int prev_tap = 0;

    always #4 clk = ~clk;

    lane_phase_calibrator #(
        .NUM_CH (NC), .WORD_W (W), .TRAIN_WORD (TRAIN),
        .NUM_TAPS (NT), .DWELL (DW), .VERIFY_LEN (VL)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .rx_words (rx_words),
        .delay_sel (delay_sel), .chosen_tap (chosen_tap), .win_width (win_width),
        .verr_cnt (verr_cnt), .no_window (no_window), .busy (busy),
        .done (done), .fail (fail), .cal_state (cal_state)
    );

    // Lane model: a good tap returns the training word, a bad one a corrupted word.
    for (genvar c = 0; c < NC; c++) begin : g_lane
        always_comb begin
            if (good[c][delay_sel] && !inj[c]) rx_words[c*W +: W] = TRAIN;
            else                                rx_words[c*W +: W] = TRAIN ^ 8'h01;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference search: longest run first, lowest start on a tie.
    task automatic ref_pick(input logic [NT-1:0] m, output int len, output int ctr);
        len = 0;
        ctr = 0;
        for (int l = NT; l >= 1 && len == 0; l--) begin
            for (int s = 0; s + l <= NT && len == 0; s++) begin
                if (((m >> s) & ((1 << l) - 1)) == ((1 << l) - 1)) begin
                    len = l;
                    ctr = s + (l - 1) / 2;
                end
            end
        end
    endtask

    // mode 0 plain, 1 scan glitch on lane 1 at tap 2 last dwell cycle,
    // 2 start pulse mid-scan, 3 verify errors on first and last vector,
    // 4 three verify errors in a row
    task automatic run_case(input logic [NT-1:0] common, input int mode);
        int len, ctr, trace_bad, exp_err;
        logic [NT-1:0] eff;
        good[0] = common | 8'h55;
        good[1] = common | 8'hAA;
        good[2] = common;
        good[3] = common | 8'h0F;
        eff = (mode == 1) ? (common & ~8'h04) : common;
        ref_pick(eff, len, ctr);
        exp_err = (mode == 3) ? 2 : (mode == 4) ? 3 : 0;
        trace_bad = 0;

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < NT * DW; k++) begin
            if (int'(delay_sel) != k / DW || !busy || cal_state != 3'd1) trace_bad++;
            inj = (mode == 1 && k == 2 * DW + DW - 1) ? 4'b0010 : 4'b0000;
            start = (mode == 2 && k == 5);
            @(negedge clk);
        end
        inj = '0;
        start = 1'b0;
        chk("R3 scan trace mismatches", trace_bad, 0);
        chk("R9 select busy", int'(busy), 1);
        @(negedge clk);

        if (len == 0) begin
            chk("R7 fail state", int'(cal_state), 5);
            chk("R7 no_window", int'(no_window), 1);
            chk("R7 delay held", int'(delay_sel), prev_tap);
            chk("R7 width zero", int'(win_width), 0);
        end else begin
            for (int v = 0; v < VL; v++) begin
                if (int'(delay_sel) != ctr) trace_bad++;
                inj = ((mode == 3 && (v == 0 || v == VL - 1)) ||
                       (mode == 4 && v >= 10 && v <= 12)) ? 4'b0001 : 4'b0000;
                @(negedge clk);
            end
            inj = '0;
            chk("R6 delay during verify", trace_bad, 0);
            chk("R5 chosen tap", int'(chosen_tap), ctr);
            chk("R5 window width", int'(win_width), len);
            chk("R8 verify errors", int'(verr_cnt), exp_err);
            chk("R8 end state", int'(cal_state), (exp_err == 0) ? 4 : 5);
            chk("R9 done flag", int'(done), (exp_err == 0) ? 1 : 0);
            chk("R9 fail flag", int'(fail), (exp_err == 0) ? 0 : 1);
            chk("R6 delay after", int'(delay_sel), ctr);
            prev_tap = ctr;
        end
    endtask

    initial begin
        for (int c = 0; c < NC; c++) good[c] = '1;
        repeat (3) @(negedge clk);
        chk("R1 state", int'(cal_state), 0);
        chk("R1 flags", int'({busy, done, fail, no_window}), 0);
        chk("R1 delay", int'(delay_sel), 0);
        chk("R1 status", int'(win_width) + int'(verr_cnt) + int'(chosen_tap), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R7 sweep of every common window
        for (int m = 0; m < (1 << NT); m++) run_case(NT'(m), 0);

        run_case(8'hFF, 1);  // R4 one-cycle glitch on one lane
        run_case(8'h3C, 2);  // R2 start ignored while busy
        run_case(8'hF0, 3);  // R8 first and last vector errors
        run_case(8'h7E, 4);  // R8 counted errors
        run_case(8'h00, 0);  // R7 keeps the tap from the failed verify
        run_case(8'h0E, 0);  // R2 restart from FAIL

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule